// File: doc/BRIEF.md
# Priority Interrupt Arbiter

This block gathers interrupt requests from external lines and from internal event pulses. It keeps one pending flag per source. When the instruction stream reaches a boundary, it picks the most urgent enabled source and hands the fetch unit a vector address. The vector address is a two-word slot that belongs to that source.

A selection takes two clock cycles from the boundary strobe. While the fetch unit reads the two words of the slot, the block holds its choice and ignores further boundaries. After the second word has been read, it pulses a one-hot acknowledge.

Each source is built in one of two flavours, chosen by a parameter:
- **Ack-clearable.** Edge-sensed external lines and latched internal events. The acknowledge clears the flag.
- **Persistent.** Level-sensed external lines and internal requests that are held until a peripheral register is accessed. The flag simply follows the request.

A sticky stack-fault flag sits beside the arbiter. Only an explicit software clear removes it.

Top module: `prio_irq_arb`

## Requirements
- R1: An external line passes a two-stage synchronizer before it can affect its pending flag. A line raised in the same cycle as a boundary strobe is not seen by that arbitration.
- R2: Source index i owns vector address VEC_BASE + 2*i. With the default base of 64, source 5 yields 74.
- R3: req_valid_o rises exactly two clock edges after the edge that samples bnd_i high while the arbiter is idle. It is still low one cycle after that edge.
- R4: A pending source is eligible only when its 2-bit level is greater than or equal to mask_i, or when its level equals 3. Level 3 cannot be masked.
- R5: Among eligible sources, the highest level wins. Ties go to the lower source index. Default levels by index 0..7 are 1,2,0,3,2,1,3,0. Indices 0-3 are ext_req_i[0..3] and indices 4-7 are int_req_i[0..3].
- R6: Once a source is selected, vec_addr_o and req_valid_o hold until the second vfetch_i pulse, and boundary strobes are ignored. A repeat request from the serviced source during that window is not buffered.
- R7: The acknowledge clears the flags of ack-clearable sources. By default these are indices 0, 1, 4 and 5. A new request on that source in the acknowledge cycle is lost, because the clear wins.
- R8: Persistent sources are never cleared by the acknowledge. By default these are indices 2 and 3 (external, level-sensed) and 6 and 7 (internal, register-cleared). They stay pending while their request input stays high.
- R9: ack_o is one-hot with the winner's index set. It lasts one cycle and appears on the edge that samples the second vfetch_i pulse, which is the same edge where req_valid_o falls. It never precedes the vector address.
- R10: stk_err_o sets one cycle after stk_set_i and stays set until stk_clr_i. When set and clear coincide, the flag stays set.
- R11: After reset, req_valid_o, ack_o and stk_err_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| ext_req_i | input | N_EXT | Raw external request lines |
| int_req_i | input | N_INT | Internal request pulses or held levels |
| mask_i | input | 2 | Mask level from the status register |
| bnd_i | input | 1 | Instruction-boundary strobe |
| vfetch_i | input | 1 | One vector word has been fetched |
| stk_set_i | input | 1 | Stack fault event |
| stk_clr_i | input | 1 | Software clear of the stack fault flag |
| req_valid_o | output | 1 | A selected vector is waiting to be fetched |
| vec_addr_o | output | ADDR_W | Address of the first word of the selected slot |
| ack_o | output | N_EXT+N_INT | One-hot acknowledge to the serviced source |
| stk_err_o | output | 1 | Sticky stack fault flag |

## Verification
Two functions can meet in one cycle: the acknowledge clearing a flag, and a fresh request on that same source. The bench provokes this by pulsing the serviced internal source exactly in the cycle where ack_o is high. It then judges the outcome by running a further arbitration with mask zero, which must find nothing pending.

The same probe is repeated during the fetch window together with a boundary strobe. There the address must stay stable and the repeat request must be lost. The stack-fault flag is likewise given a set and a clear in the same cycle, and must stay set.

// File: rtl/pia_pkg.sv
package pia_pkg;
   localparam int LVL_W = 2;
   localparam logic [LVL_W-1:0] LVL_NMI = 2'd3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARB,
      ST_FETCH1,
      ST_FETCH2,
      ST_ACK
   } arb_state_t;

   function automatic logic lvl_passes(input logic [LVL_W-1:0] lvl,
                                       input logic [LVL_W-1:0] mask);
      return (lvl >= mask) || (lvl == LVL_NMI);
   endfunction
endpackage

// File: rtl/pia_src_flag.sv
module pia_src_flag #(
   parameter bit IS_EXT      = 1'b1,
   parameter bit CLR_BY_ACK  = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic req_i,
   input  logic ack_i,
   output logic pend_o
);
   logic sig;
   logic prev_q;
   logic set;
   logic flag_q;

   generate
      if (IS_EXT) begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) sh_q <= '0;
            else          sh_q <= {sh_q[SYNC_STAGES-2:0], req_i};
         end
         assign sig = sh_q[SYNC_STAGES-1];
      end else begin : g_direct
         assign sig = req_i;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) prev_q <= 1'b0;
      else          prev_q <= sig;
   end

   // external clearable lines react to a rising edge, internal ones to the pulse
   assign set = IS_EXT ? (sig & ~prev_q) : sig;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)        flag_q <= 1'b0;
      else if (CLR_BY_ACK) flag_q <= (flag_q | set) & ~ack_i;
      else                 flag_q <= sig;
   end

   assign pend_o = flag_q;
endmodule

// File: rtl/pia_pick.sv
module pia_pick #(
   parameter int N_SRC = 8,
   parameter int IDX_W = 3,
   parameter logic [2*N_SRC-1:0] SRC_LVL = '0
) (
   input  logic [N_SRC-1:0] elig_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);
   logic [1:0] best_lvl;

   always_comb begin
      found_o  = 1'b0;
      idx_o    = '0;
      best_lvl = '0;
      for (int i = 0; i < N_SRC; i++) begin
         // strict compare: an equal level never displaces a lower index
         if (elig_i[i] && (!found_o || SRC_LVL[2*i +: 2] > best_lvl)) begin
            found_o  = 1'b1;
            idx_o    = IDX_W'(i);
            best_lvl = SRC_LVL[2*i +: 2];
         end
      end
   end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
   parameter int N_EXT       = 4,
   parameter int N_INT       = 4,
   parameter int ADDR_W      = 8,
   parameter int VEC_BASE    = 64,
   parameter int SYNC_STAGES = 2,
   parameter logic [2*(N_EXT+N_INT)-1:0] SRC_LVL = 16'h36C9,
   parameter logic [N_EXT+N_INT-1:0]     SRC_CLR = 8'h33
) (
   input  logic                   clk_i,
   input  logic                   rst_n_i,
   input  logic [N_EXT-1:0]       ext_req_i,
   input  logic [N_INT-1:0]       int_req_i,
   input  logic [1:0]             mask_i,
   input  logic                   bnd_i,
   input  logic                   vfetch_i,
   input  logic                   stk_set_i,
   input  logic                   stk_clr_i,
   output logic                   req_valid_o,
   output logic [ADDR_W-1:0]      vec_addr_o,
   output logic [N_EXT+N_INT-1:0] ack_o,
   output logic                   stk_err_o
);
   import pia_pkg::*;

   localparam int N_SRC = N_EXT + N_INT;
   localparam int IDX_W = $clog2(N_SRC);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(VEC_BASE);

   generate
      if (N_EXT < 1 || N_INT < 1) begin : g_bad_cnt
         $error("need at least one external and one internal source");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("synchronizer needs two or more stages");
      end
      if (VEC_BASE + 2 * N_SRC > (1 << ADDR_W)) begin : g_bad_addr
         $error("vector table does not fit in ADDR_W");
      end
   endgenerate

   logic [N_SRC-1:0] src_req, pend, enabled, elig_q, ack_q;
   logic [IDX_W-1:0] pick_idx, win_q;
   logic             pick_found, valid_q, stk_q;
   logic [ADDR_W-1:0] vec_q;
   arb_state_t       st_q;

   assign src_req = {int_req_i, ext_req_i};

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_src
         pia_src_flag #(
            .IS_EXT     (i < N_EXT),
            .CLR_BY_ACK (SRC_CLR[i]),
            .SYNC_STAGES(SYNC_STAGES)
         ) flag_i (
            .clk_i  (clk_i),
            .rst_n_i(rst_n_i),
            .req_i  (src_req[i]),
            .ack_i  (ack_q[i]),
            .pend_o (pend[i])
         );
         assign enabled[i] = pend[i] & lvl_passes(SRC_LVL[2*i +: 2], mask_i);
      end
   endgenerate

   pia_pick #(
      .N_SRC  (N_SRC),
      .IDX_W  (IDX_W),
      .SRC_LVL(SRC_LVL)
   ) pick_i (
      .elig_i (elig_q),
      .found_o(pick_found),
      .idx_o  (pick_idx)
   );

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         st_q    <= ST_IDLE;
         elig_q  <= '0;
         win_q   <= '0;
         vec_q   <= '0;
         valid_q <= 1'b0;
         ack_q   <= '0;
      end else begin
         ack_q <= '0;
         unique case (st_q)
            ST_IDLE: if (bnd_i) begin
               elig_q <= enabled;
               st_q   <= ST_ARB;
            end
            ST_ARB: if (pick_found) begin
               win_q   <= pick_idx;
               vec_q   <= BASE + (ADDR_W'(pick_idx) << 1);
               valid_q <= 1'b1;
               st_q    <= ST_FETCH1;
            end else begin
               st_q <= ST_IDLE;
            end
            ST_FETCH1: if (vfetch_i) st_q <= ST_FETCH2;
            ST_FETCH2: if (vfetch_i) begin
               valid_q      <= 1'b0;
               ack_q[win_q] <= 1'b1;
               st_q         <= ST_ACK;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)       stk_q <= 1'b0;
      else if (stk_set_i) stk_q <= 1'b1;
      else if (stk_clr_i) stk_q <= 1'b0;
   end

   assign req_valid_o = valid_q;
   assign vec_addr_o  = vec_q;
   assign ack_o       = ack_q;
   assign stk_err_o   = stk_q;
endmodule

// File: rtl/prio_irq_arb_chk.sv
module prio_irq_arb_chk #(
   parameter int N_SRC    = 8,
   parameter int ADDR_W   = 8,
   parameter int VEC_BASE = 64,
   parameter logic [2*N_SRC-1:0] SRC_LVL = '0
) (
   input logic              clk_i,
   input logic              rst_n_i,
   input logic [1:0]        mask_i,
   input logic              bnd_i,
   input logic              vfetch_i,
   input logic              stk_set_i,
   input logic              stk_clr_i,
   input logic              req_valid_o,
   input logic [ADDR_W-1:0] vec_addr_o,
   input logic [N_SRC-1:0]  ack_o,
   input logic              stk_err_o
);
   function automatic logic [1:0] lvl_at(input logic [ADDR_W-1:0] a);
      int idx;
      idx = (int'(a) - VEC_BASE) / 2;
      if (idx < 0 || idx >= N_SRC) return 2'd0;
      return SRC_LVL[2*idx +: 2];
   endfunction

   // R3
   valid_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(req_valid_o) |-> $past(bnd_i, 2));

   // R4
   mask_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(req_valid_o) |-> (lvl_at(vec_addr_o) >= $past(mask_i, 2) || lvl_at(vec_addr_o) == 2'd3));

   // R6
   hold_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (req_valid_o && !vfetch_i) |=> req_valid_o);

   // R6
   hold_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (req_valid_o && $past(req_valid_o)) |-> $stable(vec_addr_o));

   // R9
   ack_after_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (|ack_o) |-> ($past(req_valid_o) && !req_valid_o));

   // R9
   ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $onehot0(ack_o));

   // R10
   stk_set_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $past(stk_set_i) |-> stk_err_o);

   // R10
   stk_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ($past(stk_err_o) && !$past(stk_clr_i)) |-> stk_err_o);
endmodule

bind prio_irq_arb prio_irq_arb_chk #(
   .N_SRC   (N_EXT + N_INT),
   .ADDR_W  (ADDR_W),
   .VEC_BASE(VEC_BASE),
   .SRC_LVL (SRC_LVL)
) chk_i (
   .clk_i      (clk_i),
   .rst_n_i    (rst_n_i),
   .mask_i     (mask_i),
   .bnd_i      (bnd_i),
   .vfetch_i   (vfetch_i),
   .stk_set_i  (stk_set_i),
   .stk_clr_i  (stk_clr_i),
   .req_valid_o(req_valid_o),
   .vec_addr_o (vec_addr_o),
   .ack_o      (ack_o),
   .stk_err_o  (stk_err_o)
);

// File: tb/prio_irq_arb_tb_top.sv
module prio_irq_arb_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ext_req = '0;
   logic [3:0] int_req = '0;
   logic [1:0] mask = '0;
   logic       bnd = 1'b0, vf = 1'b0, stk_set = 1'b0, stk_clr = 1'b0;
   logic       valid;
   logic [7:0] vaddr;
   logic [7:0] ack;
   logic       stk_err;
   int         checks = 0;
   int         errors = 0;

   always #4 clk = ~clk;

   prio_irq_arb dut_i (
      .clk_i(clk), .rst_n_i(rst_n), .ext_req_i(ext_req), .int_req_i(int_req),
      .mask_i(mask), .bnd_i(bnd), .vfetch_i(vf), .stk_set_i(stk_set),
      .stk_clr_i(stk_clr), .req_valid_o(valid), .vec_addr_o(vaddr),
      .ack_o(ack), .stk_err_o(stk_err));

   function automatic int lvl(input int s);
      int t[8] = '{1, 2, 0, 3, 2, 1, 3, 0};
      return t[s];
   endfunction

   function automatic bit clr(input int s);
      return (s == 0 || s == 1 || s == 4 || s == 5);
   endfunction

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put(input int s, input logic v);
      if (s < 4) ext_req[s] = v;
      else       int_req[s-4] = v;
   endtask

   task automatic raise(input int s);
      put(s, 1'b1);
      if (s == 4 || s == 5) begin
         cyc(1);
         put(s, 1'b0);
      end
      cyc(4);
   endtask

   task automatic drop(input int s);
      put(s, 1'b0);
      cyc(4);
   endtask

   task automatic arb(input logic [1:0] m, output bit got, output int addr);
      mask = m;
      bnd  = 1'b1;
      cyc(1);
      bnd = 1'b0;
      chk(valid == 1'b0, "R3 valid early", int'(valid), 0);
      cyc(1);
      got  = valid;
      addr = int'(vaddr);
   endtask

   // inj 1: repeat source-4 pulse plus boundary inside fetch window; inj 2: pulse in ack cycle
   task automatic serve(input int s, input int inj);
      int a0;
      a0 = int'(vaddr);
      vf = 1'b1;
      if (inj == 1) begin
         int_req[0] = 1'b1;
         bnd        = 1'b1;
      end
      cyc(1);
      int_req[0] = 1'b0;
      bnd        = 1'b0;
      chk(valid == 1'b1 && ack == 8'd0, "R6 held between fetches", int'(valid), 1);
      chk(int'(vaddr) == a0, "R6 addr stable", int'(vaddr), a0);
      cyc(1);
      vf = 1'b0;
      chk(valid == 1'b0, "R9 valid falls with ack", int'(valid), 0);
      chk(ack == 8'(1 << s), "R9 ack onehot", int'(ack), 1 << s);
      if (inj == 2) int_req[0] = 1'b1;
      cyc(1);
      int_req[0] = 1'b0;
      chk(ack == 8'd0, "R9 ack one cycle", int'(ack), 0);
   endtask

   task automatic drain();
      bit got;
      int a;
      for (int k = 0; k < 12; k++) begin
         arb(2'd0, got, a);
         if (!got) break;
         serve((a - 64) / 2, 0);
      end
   endtask

   initial begin
      bit got;
      int a;
      bit exp;
      int w;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R11
      chk(valid == 0 && ack == 0 && stk_err == 0, "R11 reset state", int'(valid) + int'(ack) + int'(stk_err), 0);

      // R1: line raised together with the strobe is invisible to that round
      ext_req[0] = 1'b1;
      arb(2'd0, got, a);
      chk(got == 1'b0, "R1 sync delay", int'(got), 0);
      cyc(3);
      ext_req[0] = 1'b0;
      cyc(3);
      drain();

      // R2 R4 R7 R8: every source alone under every mask
      for (int s = 0; s < 8; s++) begin
         for (int m = 0; m < 4; m++) begin
            raise(s);
            arb(2'(m), got, a);
            exp = (lvl(s) >= m) || (lvl(s) == 3);
            chk(got == exp, "R4 mask rule", int'(got), int'(exp));
            if (got) begin
               chk(a == 64 + 2 * s, "R2 vector slot", a, 64 + 2 * s);
               serve(s, 0);
               arb(2'd0, got, a);
               if (clr(s)) chk(got == 1'b0, "R7 ack clears flag", int'(got), 0);
               else        chk(got == 1'b1 && a == 64 + 2 * s, "R8 flag persists", a, 64 + 2 * s);
               if (got) serve((a - 64) / 2, 0);
            end
            drop(s);
            drain();
         end
      end

      // R5: every pair of sources, unmasked
      for (int x = 0; x < 8; x++) begin
         for (int y = x + 1; y < 8; y++) begin
            raise(x);
            raise(y);
            w = (lvl(y) > lvl(x)) ? y : x;
            arb(2'd0, got, a);
            chk(got && a == 64 + 2 * w, "R5 priority pick", a, 64 + 2 * w);
            if (got) serve((a - 64) / 2, 0);
            drop(x);
            drop(y);
            drain();
         end
      end

      // R6: repeat request and boundary during the fetch window are lost
      raise(4);
      arb(2'd0, got, a);
      chk(got && a == 72, "R6 select src4", a, 72);
      if (got) serve(4, 1);
      arb(2'd0, got, a);
      chk(got == 1'b0, "R6 repeat not buffered", int'(got), 0);
      if (got) serve((a - 64) / 2, 0);
      drain();

      // R7: new request coinciding with the acknowledge clear is lost
      raise(4);
      arb(2'd0, got, a);
      if (got) serve(4, 2);
      arb(2'd0, got, a);
      chk(got == 1'b0, "R7 clear wins over coincident pulse", int'(got), 0);
      if (got) serve((a - 64) / 2, 0);
      drain();

      // R10: sticky stack fault
      stk_set = 1'b1;
      cyc(1);
      stk_set = 1'b0;
      chk(stk_err == 1'b1, "R10 set", int'(stk_err), 1);
      cyc(5);
      chk(stk_err == 1'b1, "R10 sticky", int'(stk_err), 1);
      stk_set = 1'b1;
      stk_clr = 1'b1;
      cyc(1);
      stk_set = 1'b0;
      stk_clr = 1'b0;
      chk(stk_err == 1'b1, "R10 set beats clear", int'(stk_err), 1);
      stk_clr = 1'b1;
      cyc(1);
      stk_clr = 1'b0;
      chk(stk_err == 1'b0, "R10 clear", int'(stk_err), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule